// File: doc/BRIEF.md
# Two-Level Predecoded Row Decoder

This block converts a binary row address into a one-hot vector of word-line enables using two decode stages. The first stage cuts the address into 2-bit slices and turns each slice into four one-hot intermediate lines. The second stage forms every row enable as the AND of exactly one intermediate line from each slice. For the default 6-bit address this means 64 row gates of three inputs each, instead of 64 gates of six inputs each.

The intermediate lines form a bus that is brought out of the block. Other final decoders elsewhere in the array can use these lines without building their own first stage. An enable input forces every line low. A parameter places an output register on the word lines, clocked on the rising edge with an asynchronous active-low reset. With the register bypassed, the path from address to word line is purely combinational.

Top module: `rowdec_2lvl`

## Requirements
- R1: While rst_n is low, the registered word lines are all zero.
- R2: With en high, exactly one word line is high, and its index equals the binary value of addr, where addr[0] is the least significant bit.
- R3: With en low, all word lines are low, whatever the address.
- R4: The predecode bus holds one 4-line group per address pair. Group g occupies bits [4g+3:4g] and decodes addr[2g+1:2g]. Line j of that group is high when the pair equals j. With en high, each group has exactly one line set.
- R5: With en low, every predecode line is low.
- R6: Row k is high exactly when three lines are all high: line k[1:0] of group 0, line k[3:2] of group 1 and line k[5:4] of group 2.
- R7: With the register present (REG_OUT=1), the word lines show the decode of en and addr as sampled at the previous rising clock edge. They do not change between edges.
- R8: The predecode bus is combinational in both modes. It follows en and addr within the same cycle.
- R9: With the register bypassed (REG_OUT=0), the word lines follow en and addr combinationally, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional word-line register |
| rst_n | input | 1 | Asynchronous active-low reset of the word-line register |
| en | input | 1 | Decode enable; when low, all outputs are forced low |
| addr | input | ADDR_W | Binary row address, bit 0 least significant |
| wl | output | 2**ADDR_W | One-hot word-line enables |
| predec | output | (ADDR_W/GRP_W)*2**GRP_W | Intermediate one-hot lines, grouped per address slice |

## Verification
The hardest behaviour to observe from the ports is the boundary between the combinational predecode path and the registered word lines. A new address must move the predecode bus at once while the word lines hold the old row until the next rising edge. To reach this, the stimulus drives each new address and enable at the falling edge. It probes the word lines one step later, before the rise, and then again after the rise. The address sweep covers all 64 rows in order. A pseudo-random sequence then toggles enable while the address keeps moving, so that rows are dropped and selected again at every position.

// File: rtl/rowdec_pkg.sv
`timescale 1ns/1ps
package rowdec_pkg;

  // number of address slices fed to the first stage
  function automatic int n_groups(input int addr_w, input int grp_w);
    return addr_w / grp_w;
  endfunction

  // one-hot lines produced per slice
  function automatic int n_lines(input int grp_w);
    return 1 << grp_w;
  endfunction

  // which line of slice 'grp' a given row taps
  function automatic int row_field(input int row, input int grp, input int grp_w);
    return (row >> (grp * grp_w)) & ((1 << grp_w) - 1);
  endfunction

endpackage

// File: rtl/rowdec_predec.sv
`timescale 1ns/1ps
// First stage: one address slice into one-hot lines
module rowdec_predec #(
  parameter int GRP_W = 2,
  parameter int LINES = 1 << GRP_W
) (
  input  logic             en,
  input  logic [GRP_W-1:0] sel,
  output logic [LINES-1:0] lines
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = en & (sel == GRP_W'(i));
  end

endmodule

// File: rtl/rowdec_final_plane.sv
`timescale 1ns/1ps
// Second stage: each row is the AND of one line per slice
module rowdec_final_plane #(
  parameter int GRP_W = 2,
  parameter int NGRP  = 3,
  parameter int LINES = 4,
  parameter int ROWS  = 64
) (
  input  logic [NGRP*LINES-1:0] pre,
  output logic [ROWS-1:0]       rows
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [NGRP-1:0] taps;
    for (genvar g = 0; g < NGRP; g++) begin : g_tap
      assign taps[g] = pre[g*LINES + rowdec_pkg::row_field(r, g, GRP_W)];
    end
    assign rows[r] = &taps;
  end

endmodule

// File: rtl/rowdec_out_stage.sv
`timescale 1ns/1ps
// Optional word-line register
module rowdec_out_stage #(
  parameter int  ROWS    = 64,
  parameter bit  REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] d,
  output logic [ROWS-1:0] q
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end else begin : g_bypass
    assign q = d;
  end

endmodule

// File: rtl/rowdec_2lvl.sv
`timescale 1ns/1ps
module rowdec_2lvl #(
  parameter int ADDR_W  = 6,
  parameter int GRP_W   = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   en,
  input  logic [ADDR_W-1:0]                      addr,
  output logic [(1<<ADDR_W)-1:0]                 wl,
  output logic [(ADDR_W/GRP_W)*(1<<GRP_W)-1:0]   predec
);

  localparam int NGRP  = rowdec_pkg::n_groups(ADDR_W, GRP_W);
  localparam int LINES = rowdec_pkg::n_lines(GRP_W);
  localparam int ROWS  = 1 << ADDR_W;

  // decode before the optional register, visible to the checker
  logic [ROWS-1:0] row_raw;

  for (genvar g = 0; g < NGRP; g++) begin : g_slice
    rowdec_predec #(.GRP_W(GRP_W), .LINES(LINES)) u_pre (
      .en    (en),
      .sel   (addr[g*GRP_W +: GRP_W]),
      .lines (predec[g*LINES +: LINES])
    );
  end

  rowdec_final_plane #(.GRP_W(GRP_W), .NGRP(NGRP), .LINES(LINES), .ROWS(ROWS)) u_plane (
    .pre  (predec),
    .rows (row_raw)
  );

  rowdec_out_stage #(.ROWS(ROWS), .REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (row_raw),
    .q     (wl)
  );

endmodule

// File: rtl/rowdec_2lvl_chk.sv
`timescale 1ns/1ps
module rowdec_2lvl_chk #(
  parameter int ADDR_W  = 6,
  parameter int GRP_W   = 2,
  parameter bit REG_OUT = 1'b1
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 en,
  input logic [(1<<ADDR_W)-1:0]               wl,
  input logic [(ADDR_W/GRP_W)*(1<<GRP_W)-1:0] predec,
  input logic [(1<<ADDR_W)-1:0]               row_raw
);

  localparam int NGRP = ADDR_W / GRP_W;

  // R2
  wl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wl));

  // R2
  raw_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $countones(row_raw) == 1);

  // R3
  raw_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> row_raw == '0);

  // R4
  predec_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $countones(predec) == NGRP);

  // R5
  predec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> predec == '0);

  if (REG_OUT) begin : g_reg_chk
    // R1
    reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> wl == '0);

    // R7
    wl_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> wl == $past(row_raw));

    // R3
    wl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(en)) |-> wl == '0);
  end else begin : g_comb_chk
    // R9
    wl_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wl == row_raw);
  end

endmodule

bind rowdec_2lvl rowdec_2lvl_chk #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .REG_OUT(REG_OUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .wl      (wl),
  .predec  (predec),
  .row_raw (row_raw)
);

// File: tb/rowdec_2lvl_tb.sv
`timescale 1ns/1ps
module rowdec_2lvl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic [5:0]  addr = 6'd5;
  logic [63:0] wl, wl_c;
  logic [11:0] predec, pre_c;
  logic [63:0] exp_wl;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rowdec_2lvl #(.REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .addr(addr), .wl(wl), .predec(predec));

  rowdec_2lvl #(.REG_OUT(1'b0)) u_dut_comb (
    .clk(clk), .rst_n(rst_n), .en(en), .addr(addr), .wl(wl_c), .predec(pre_c));

  // reference model of the registered word lines
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_wl <= 64'd0;
    else        exp_wl <= en ? (64'd1 << addr) : 64'd0;
  end

  function automatic logic [11:0] exp_pre(input logic e, input logic [5:0] a);
    logic [11:0] r = '0;
    for (int g = 0; g < 3; g++) begin
      int pair = (int'(a) / (1 << (2*g))) % 4;
      r[g*4 + pair] = e;
    end
    return r;
  endfunction

  function automatic logic [63:0] flat_dec(input logic e, input logic [5:0] a);
    logic [63:0] r = '0;
    for (int k = 0; k < 64; k++) r[k] = e && (int'(a) == k);
    return r;
  endfunction

  function automatic logic [63:0] product(input logic [11:0] p);
    logic [63:0] r;
    for (int k = 0; k < 64; k++)
      r[k] = p[k % 4] & p[4 + (k / 4) % 4] & p[8 + (k / 16) % 4];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic [5:0] a);
    logic [63:0] prev;
    @(negedge clk);
    prev = exp_wl;
    en = e;
    addr = a;
    #1;
    chk("R7", wl, prev);
    chk("R8", {52'd0, predec}, {52'd0, exp_pre(e, a)});
    chk("R9", wl_c, flat_dec(e, a));
    @(posedge clk);
    #5;
    chk(e ? "R2" : "R3", wl, exp_wl);
    chk("R2", 64'($countones(wl)), e ? 64'd1 : 64'd0);
    chk(e ? "R4" : "R5", {52'd0, predec}, {52'd0, exp_pre(e, a)});
    chk("R6", wl_c, product(pre_c));
  endtask

  initial begin
    #(64'd20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    // R1: held in reset with an active request
    repeat (2) @(posedge clk);
    #5;
    chk("R1", wl, 64'd0);
    chk("R8", {52'd0, predec}, {52'd0, exp_pre(1'b1, 6'd5)});
    @(negedge clk);
    rst_n = 1'b1;
    // full sweep of every row, both ends included
    for (int k = 0; k < 64; k++) step(1'b1, 6'(k));
    // disabled at assorted addresses, including both ends
    step(1'b0, 6'd0);
    step(1'b0, 6'd63);
    step(1'b0, 6'd21);
    step(1'b0, 6'd42);
    // hold the same input for several edges
    step(1'b1, 6'd63);
    step(1'b1, 6'd63);
    step(1'b1, 6'd0);
    step(1'b1, 6'd0);
    // pseudo-random mix of enable and address
    for (int n = 0; n < 60; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[7] | lfsr[3], lfsr[5:0]);
    end
    // R1: reset asserted again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", wl, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 6'd33);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule